// File: doc/BRIEF.md
# VGA Planar Read Mode Unit

This block turns one 32-bit frame buffer word into the byte that goes back to the host on a read. The word holds four colour planes of eight bits each. Plane b is bits [8b+7:8b] of the word. The block has two conversions. The first is plane select: one plane byte is returned. The second is colour compare: for each of the eight pixel positions, the block tests whether that pixel's four-plane colour matches a reference colour. This turns four bits per pixel into one bit per pixel.

In plane select, the chain mode input decides which plane is returned. In the normal layout, a 2-bit plane register picks the plane. In odd/even layout, address bit 0 replaces the low bit of that register. In the four-way chained layout, the two low address bits pick the plane on their own. In colour compare, a per-plane enable mask says which planes take part in the test.

The result is registered. A valid pulse appears one clock after each accepted read word, and the output byte holds its value between reads.

Top module: `vga_read_unit`

## Requirements
- R1: After reset, `host_valid_o` is 0 and `host_data_o` is 8'h00.
- R2: `host_valid_o` is 1 in the cycle after a cycle in which `rd_valid_i` is 1, and 0 in the cycle after a cycle in which `rd_valid_i` is 0.
- R3: With `cmp_mode_i`=0 and `chain_i`=2'b00, the output is plane `plane_sel_i`, that is `rd_data_i[8*plane_sel_i +: 8]`.
- R4: With `cmp_mode_i`=0 and `chain_i`=2'b01 (odd/even), the plane is {`plane_sel_i[1]`, `addr_lo_i[0]`}.
- R5: With `cmp_mode_i`=0 and `chain_i`=2'b10 (four-way chain), the plane is `addr_lo_i[1:0]`, and `plane_sel_i` has no effect.
- R6: The chain code 2'b11 behaves exactly like 2'b00.
- R7: With `cmp_mode_i`=1, output bit n is 1 when, for every plane b with `cmp_care_i[b]`=1, bit n of plane b equals `cmp_color_i[b]`. Otherwise bit n is 0. Planes with `cmp_care_i[b]`=0 are ignored.
- R8: With `cmp_mode_i`=1 and `cmp_care_i`=4'b0000, the output is 8'hFF whatever the data is.
- R9: In a cycle with `rd_valid_i`=0, `host_data_o` keeps its previous value in the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read word present this cycle |
| rd_data_i | input | 32 | Four-plane frame buffer word, plane b in bits [8b+7:8b] |
| addr_lo_i | input | 2 | Low bits of the read address |
| chain_i | input | 2 | Layout: 00 normal, 01 odd/even, 10 four-way chain, 11 as normal |
| cmp_mode_i | input | 1 | 0 plane select, 1 colour compare |
| plane_sel_i | input | 2 | Plane chosen in plane select |
| cmp_color_i | input | 4 | Reference colour, bit b for plane b |
| cmp_care_i | input | 4 | Planes taking part in the compare, 1 = included |
| host_data_o | output | 8 | Byte returned to the host |
| host_valid_o | output | 1 | Byte valid, one cycle after `rd_valid_i` |

## Verification
The hardest case to reach is in colour compare with a partial plane mask. Here a pixel fails on one included plane and differs only on excluded planes. Random words rarely make a whole byte come out distinct under such a mask. For this reason, directed words are built from a chosen colour, with single excluded planes flipped, so that ignored and counted mismatches sit side by side in one byte. Random mixes of chain codes, addresses and plane registers are also used, with idle cycles in between, so that the address override is seen working against every register value and the hold behaviour is seen under changing inputs.

// File: rtl/vga_read_unit.sv
module vga_read_unit #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid_i,
  input  logic [4*PW-1:0] rd_data_i,
  input  logic [1:0]    addr_lo_i,
  input  logic [1:0]    chain_i,
  input  logic          cmp_mode_i,
  input  logic [1:0]    plane_sel_i,
  input  logic [3:0]    cmp_color_i,
  input  logic [3:0]    cmp_care_i,
  output logic [PW-1:0] host_data_o,
  output logic          host_valid_o
);
  localparam int NP = 4;

  logic [1:0]    plane;
  logic [PW-1:0] sel_byte;
  logic [PW-1:0] cmp_byte;

  always_comb begin
    case (chain_i)
      2'b01:   plane = {plane_sel_i[1], addr_lo_i[0]};
      2'b10:   plane = addr_lo_i;
      default: plane = plane_sel_i;
    endcase
  end

  assign sel_byte = rd_data_i[plane*PW +: PW];

  always_comb begin
    for (int n = 0; n < PW; n++) begin
      cmp_byte[n] = 1'b1;
      for (int b = 0; b < NP; b++)
        if (cmp_care_i[b] && (rd_data_i[b*PW+n] != cmp_color_i[b]))
          cmp_byte[n] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_data_o  <= '0;
      host_valid_o <= 1'b0;
    end else begin
      host_valid_o <= rd_valid_i;
      if (rd_valid_i) host_data_o <= cmp_mode_i ? cmp_byte : sel_byte;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> host_valid_o);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> !host_valid_o);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> $stable(host_data_o));
  a_r8_all_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && cmp_mode_i && cmp_care_i == 4'b0000) |=> host_data_o == '1);
  a_r5_chain4_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && !cmp_mode_i && chain_i == 2'b10)
      |=> host_data_o == PW'($past(rd_data_i >> (PW * addr_lo_i))));
endmodule

// File: tb/test_vga_read_unit.sv
module test_vga_read_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic [1:0]  addr_lo_i = '0, chain_i = '0, plane_sel_i = '0;
  logic        cmp_mode_i = 1'b0;
  logic [3:0]  cmp_color_i = '0, cmp_care_i = '0;
  logic [7:0]  host_data_o;
  logic        host_valid_o;

  int tests = 0, fails = 0;
  logic [7:0] last = 8'h00;

  always #2 clk = ~clk;

  vga_read_unit i_vga_read_unit (.*);

  function automatic logic [7:0] model(input logic [31:0] d, input logic [1:0] a,
      input logic [1:0] ch, input logic m, input logic [1:0] ps,
      input logic [3:0] col, input logic [3:0] care);
    logic [1:0] p;
    logic [7:0] r;
    if (m) begin
      for (int n = 0; n < 8; n++) begin
        r[n] = 1'b1;
        for (int b = 0; b < 4; b++)
          if (care[b] && d[8*b+n] != col[b]) r[n] = 1'b0;
      end
      return r;
    end
    p = (ch == 2'b10) ? a : (ch == 2'b01) ? {ps[1], a[0]} : ps;
    return d[8*p +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic v, input logic [31:0] d, input logic [1:0] a,
      input logic [1:0] ch, input logic m, input logic [1:0] ps,
      input logic [3:0] col, input logic [3:0] care);
    logic [7:0] exp;
    rd_valid_i = v; rd_data_i = d; addr_lo_i = a; chain_i = ch;
    cmp_mode_i = m; plane_sel_i = ps; cmp_color_i = col; cmp_care_i = care;
    exp = v ? model(d, a, ch, m, ps, col, care) : last;
    @(negedge clk);
    check(v ? req : "R9", host_data_o, exp);
    check("R2", {7'b0, host_valid_o}, {7'b0, v});
    last = exp;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", host_data_o, 8'h00);
    check("R1", {7'b0, host_valid_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 normal planes
    for (int p = 0; p < 4; p++) rd("R3", 1, 32'h44332211, 2'b11, 2'b00, 0, 2'(p), 0, 0);
    // R4 odd/even
    rd("R4", 1, 32'h44332211, 2'b01, 2'b01, 0, 2'b10, 0, 0);
    rd("R4", 1, 32'h44332211, 2'b10, 2'b01, 0, 2'b01, 0, 0);
    // R5 chain4 ignores plane register
    rd("R5", 1, 32'hDDCCBBAA, 2'b01, 2'b10, 0, 2'b11, 0, 0);
    rd("R5", 1, 32'hDDCCBBAA, 2'b11, 2'b10, 0, 2'b00, 0, 0);
    // R6 code 3 as normal
    rd("R6", 1, 32'hDDCCBBAA, 2'b01, 2'b11, 0, 2'b10, 0, 0);
    // R7 partial mask: colour 0101, plane 1 excluded and flipped in bits 0..3
    rd("R7", 1, {8'h00, 8'hFF, 8'h0F, 8'hFF}, 2'b00, 2'b00, 1, 0, 4'b0101, 4'b1101);
    rd("R7", 1, {8'h00, 8'hF0, 8'h00, 8'hFF}, 2'b00, 2'b00, 1, 0, 4'b0101, 4'b1111);
    // R8 nothing cared
    rd("R8", 1, 32'h12345678, 2'b00, 2'b00, 1, 0, 4'b1010, 4'b0000);
    // R9 idle holds
    rd("R9", 0, 32'hFFFFFFFF, 2'b10, 2'b10, 0, 2'b11, 4'hF, 4'hF);
    for (int i = 0; i < 400; i++)
      rd(($urandom % 2) ? "R7" : "R3", ($urandom % 4) != 0, $urandom, 2'($urandom), 2'($urandom),
         1'($urandom), 2'($urandom), 4'($urandom), 4'($urandom));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule